// File: doc/BRIEF.md
# SPI Frame Timing Generator

This block drives one serial peripheral frame at a time. It turns a start pulse into a complete chip-select window, a serial clock and a data exchange. A bank of configuration slots is presented on a flat input bus, and a select input chooses the slot for the next frame. Each slot sets the frame length (4 to 16 bits), idle clock level, sampling edge and bit order. It also sets three timings: the bit rate, the gap between selecting the device and the first clock edge, and the gap between the last clock edge and releasing the select.

All three timings are built the same way: a small odd-or-prime prescaler multiplied by a power-of-two-style scaler. This keeps the codes short and still covers a wide range. At the end of a frame the block raises a one-cycle done pulse, with the received word right-aligned. In continuous mode the select line stays asserted after the frame, so the next frame can follow with no deselect gap.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is asserted, cs_n is 1, sclk is 0, done is 0, mosi is 0 and rx_data is 0.
- R2: A start in idle with a legal size asserts cs_n low from the following cycle. The first sclk edge comes L cycles after that, plus one half bit when the phase bit is 0. L = Lp·2^(Ls+1), with lead prescaler code 0..3 giving Lp = 1, 3, 5, 7 and Ls the 4-bit lead scaler code.
- R3: Every sclk half period lasts P·S/2 system cycles. Baud prescaler code 0..3 gives P = 2, 3, 5, 7. Baud scaler code 0..3 gives S = 2, 4, 6, 8, and code k of 4 or more gives S = 2^k.
- R4: A frame has exactly 2·(F+1) sclk edges, where F is the 4-bit size field holding bits minus one.
- R5: sclk rests at the polarity bit outside the bit phase, including both delays. With phase 0, data is sampled on odd-numbered edges (leading). With phase 1, it is sampled on even-numbered edges (trailing). mosi changes only on the other edges.
- R6: With the bit-order bit at 1, bit 0 of tx_data is sent first. With it at 0, bit F is sent first. miso bits are assembled in the same order.
- R7: done is a one-cycle pulse. It comes T cycles after the last sclk edge, plus one half bit when the phase bit is 1. T uses the trail prescaler and scaler with the same coding as R2. cs_n rises in the same cycle as done unless the frame is continuous.
- R8: While done is high, rx_data holds the F+1 received bits right-aligned, with the bits above them at zero.
- R9: If cont is 1 at start, cs_n stays low after done until a later frame started with cont at 0 ends.
- R10: A start whose size field is 0, 1 or 2 is ignored: cs_n stays high and no done follows.
- R11: A start during a frame is ignored. The frame keeps its timing, and only one done is produced.
- R12: cfg_sel picks slot k, which occupies cfg_bank bits [25k+24:25k]. Inside a slot: [24:21] size, [20] polarity, [19] phase, [18] bit order, [17:16] baud prescaler, [15:12] baud scaler, [11:10] lead prescaler, [9:6] lead scaler, [5:4] trail prescaler, [3:0] trail scaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank | input | NUM_CFG*25 | Packed configuration slots |
| cfg_sel | input | SEL_W | Slot used by the next start |
| start | input | 1 | Start pulse for one frame |
| cont | input | 1 | Keep select asserted after this frame |
| tx_data | input | 16 | Word to send, right-aligned |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
The bench acts as a peripheral that samples mosi and drives miso on the edges the phase bit names. It runs frames that mix every polarity/phase pair, both bit orders, and sizes of 4, 5, 8, 9, 12 and 16 bits. A design that sampled on the wrong edge, or aligned a short word badly, would return a shifted or reversed word. An off-by-one in a counter would show up as a wrong lead gap, a wrong trail gap or an uneven half period. Wrong half-bit handling would make lead and trail differ between the two phases. Directed cases aim at too-short size codes, a stray start in mid-frame that must not restart the lead delay, and a continuous frame whose select must not blink before the next frame.

// File: rtl/spi_ft_pkg.sv
package spi_ft_pkg;

  localparam int DATA_W      = 16;
  localparam int SIZE_W      = 4;
  localparam int PRE_W       = 2;
  localparam int SCL_W       = 4;
  localparam int CNT_W       = 19;
  localparam int HCNT_W      = SIZE_W + 1;
  localparam int MIN_SIZE_M1 = 3;

  typedef struct packed {
    logic [SIZE_W-1:0] size_m1;
    logic              cpol;
    logic              cpha;
    logic              lsb_first;
    logic [PRE_W-1:0]  baud_pre;
    logic [SCL_W-1:0]  baud_scl;
    logic [PRE_W-1:0]  lead_pre;
    logic [SCL_W-1:0]  lead_scl;
    logic [PRE_W-1:0]  trail_pre;
    logic [SCL_W-1:0]  trail_scl;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} ft_state_e;

  // Half of one serial bit period, in system cycles.
  function automatic logic [CNT_W-1:0] half_cycles(input logic [PRE_W-1:0] pre,
                                                   input logic [SCL_W-1:0] scl);
    logic [CNT_W-1:0] base;
    if (scl < SCL_W'(4)) base = CNT_W'(scl) + CNT_W'(1);
    else                 base = CNT_W'(1) << (scl - SCL_W'(1));
    case (pre)
      2'd0:    return base << 1;
      2'd1:    return (base << 1) + base;
      2'd2:    return (base << 2) + base;
      default: return (base << 3) - base;
    endcase
  endfunction

  // Lead or trail delay, in system cycles.
  function automatic logic [CNT_W-1:0] delay_cycles(input logic [PRE_W-1:0] pre,
                                                    input logic [SCL_W-1:0] scl);
    logic [CNT_W-1:0] base;
    base = CNT_W'(1) << ({1'b0, scl} + 5'd1);
    case (pre)
      2'd0:    return base;
      2'd1:    return (base << 1) + base;
      2'd2:    return (base << 2) + base;
      default: return (base << 3) - base;
    endcase
  endfunction

endpackage

// File: rtl/spi_ft_count.sv
module spi_ft_count #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = val_i;
    else if (!zero_o) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: an expired counter rests at zero until reloaded
  a_r3_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/spi_ft_shift.sv
module spi_ft_shift #(
  parameter int DATA_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              lsb_i,
  input  logic [SIZE_W-1:0] size_m1_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              lsb_q, lsb_d;
  logic [SIZE_W-1:0] pad_q, pad_d, load_pad;

  assign load_pad = SIZE_W'(DATA_W - 1) - size_m1_i;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    lsb_d = lsb_q;
    pad_d = pad_q;
    if (load_i) begin
      tx_d  = lsb_i ? tx_i : (tx_i << load_pad);
      rx_d  = '0;
      lsb_d = lsb_i;
      pad_d = load_pad;
    end else begin
      if (shift_i)
        tx_d = lsb_q ? (tx_q >> 1) : (tx_q << 1);
      if (sample_i)
        rx_d = lsb_q ? {miso_i, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      lsb_q <= 1'b0;
      pad_q <= '0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      lsb_q <= lsb_d;
      pad_q <= pad_d;
    end
  end

  assign mosi_o = lsb_q ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_o   = lsb_q ? (rx_q >> pad_q) : rx_q;

  // R5: a sampling edge and a data-change edge never share a cycle
  a_r5_sample_shift_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_i && shift_i));

endmodule

// File: rtl/spi_ft_ctrl.sv
module spi_ft_ctrl
  import spi_ft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  input  cfg_t             cfg_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             load_o,
  output logic             sample_o,
  output logic             shift_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             done_o
);

  ft_state_e          state_q, state_d;
  cfg_t               cfg_q, cfg_d;
  logic               hold_q, hold_d;
  logic [HCNT_W-1:0]  hcnt_q, hcnt_d, last_half;
  logic               cs_n_q, cs_n_d;
  logic               done_q, done_d;
  logic               sclk_q, sclk_d;
  logic               legal;

  assign last_half = {cfg_q.size_m1, 1'b1};
  assign legal     = (cfg_i.size_m1 >= SIZE_W'(MIN_SIZE_M1));

  always_comb begin
    state_d    = state_q;
    cfg_d      = cfg_q;
    hold_d     = hold_q;
    hcnt_d     = hcnt_q;
    cs_n_d     = cs_n_q;
    done_d     = 1'b0;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    load_o     = 1'b0;
    sample_o   = 1'b0;
    shift_o    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && legal) begin
          load_o     = 1'b1;
          cfg_d      = cfg_i;
          hold_d     = cont_i;
          cs_n_d     = 1'b0;
          state_d    = ST_LEAD;
          cnt_load_o = 1'b1;
          cnt_val_o  = delay_cycles(cfg_i.lead_pre, cfg_i.lead_scl) - CNT_W'(1);
        end
      end
      ST_LEAD: begin
        if (cnt_zero_i) begin
          state_d    = ST_XFER;
          hcnt_d     = '0;
          cnt_load_o = 1'b1;
          cnt_val_o  = half_cycles(cfg_q.baud_pre, cfg_q.baud_scl) - CNT_W'(1);
        end
      end
      ST_XFER: begin
        if (cnt_zero_i) begin
          cnt_load_o = 1'b1;
          if (hcnt_q == last_half) begin
            state_d   = ST_TRAIL;
            cnt_val_o = delay_cycles(cfg_q.trail_pre, cfg_q.trail_scl) - CNT_W'(1);
          end else begin
            hcnt_d    = hcnt_q + HCNT_W'(1);
            cnt_val_o = half_cycles(cfg_q.baud_pre, cfg_q.baud_scl) - CNT_W'(1);
            sample_o  = hcnt_d[0];
            shift_o   = !hcnt_d[0];
          end
        end
      end
      default: begin
        if (cnt_zero_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cs_n_d  = !hold_q;
        end
      end
    endcase
    sclk_d = (state_d == ST_XFER) ? (cfg_d.cpol ^ cfg_d.cpha ^ hcnt_d[0]) : cfg_d.cpol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      hold_q  <= 1'b0;
      hcnt_q  <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      hold_q  <= hold_d;
      hcnt_q  <= hcnt_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      sclk_q  <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;
  assign done_o = done_q;

  // R7: done lasts exactly one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: a start with a too-short size leaves the block idle
  a_r10_short_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && !legal) |=> (state_q == ST_IDLE));

  // R5: the clock rests at the polarity level outside the bit phase
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_XFER) |-> (sclk_q == cfg_q.cpol));

  // R2: the select is held for the whole frame
  a_r2_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !cs_n_q);

  // R4: the half-bit index never passes the last half of the frame
  a_r4_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER) |-> (hcnt_q <= last_half));

  // R11: the latched configuration does not change while busy
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(cfg_q)));

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
  import spi_ft_pkg::*;
#(
  parameter int NUM_CFG = 4,
  localparam int SEL_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CFG*CFG_W-1:0] cfg_bank,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic                     start,
  input  logic                     cont,
  input  logic [DATA_W-1:0]        tx_data,
  input  logic                     miso,
  output logic                     sclk,
  output logic                     mosi,
  output logic                     cs_n,
  output logic                     done,
  output logic [DATA_W-1:0]        rx_data
);

  cfg_t             slot [NUM_CFG];
  cfg_t             cfg_pick;
  logic             cnt_load, cnt_zero, frame_load, sample, shift;
  logic [CNT_W-1:0] cnt_val;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
    assign slot[g] = cfg_t'(cfg_bank[g*CFG_W +: CFG_W]);
  end

  assign cfg_pick = slot[cfg_sel];

  spi_ft_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cont_i     (cont),
    .cfg_i      (cfg_pick),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .load_o     (frame_load),
    .sample_o   (sample),
    .shift_o    (shift),
    .sclk_o     (sclk),
    .cs_n_o     (cs_n),
    .done_o     (done)
  );

  spi_ft_count #(.W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  spi_ft_shift #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (frame_load),
    .lsb_i     (cfg_pick.lsb_first),
    .size_m1_i (cfg_pick.size_m1),
    .tx_i      (tx_data),
    .sample_i  (sample),
    .shift_i   (shift),
    .miso_i    (miso),
    .mosi_o    (mosi),
    .rx_o      (rx_data)
  );

endmodule

// File: tb/spi_frame_timer_test.sv
module spi_frame_timer_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [99:0]  cfg_bank;
  logic [1:0]   cfg_sel;
  logic         start, cont, miso;
  logic [15:0]  tx_data;
  logic         sclk, mosi, cs_n, done;
  logic [15:0]  rx_data;
  int           nchk = 0;
  int           nerr = 0;

  always #4 clk = ~clk;

  spi_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_bank(cfg_bank), .cfg_sel(cfg_sel),
    .start(start), .cont(cont), .tx_data(tx_data), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(done), .rx_data(rx_data)
  );

  // {sel, size, cpol, cpha, lsb, bpre, bscl, lpre, lscl, tpre, tscl, tx, peer word, cont}
  localparam logic [59:0] VEC [6] = '{
    {2'd0, 4'd7,  1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 16'h12A5, 16'h873C, 1'b0},
    {2'd1, 4'd15, 1'b1, 1'b0, 1'b1, 2'd1, 4'd1, 2'd1, 4'd1, 2'd2, 4'd0, 16'hB38E, 16'h5A17, 1'b0},
    {2'd2, 4'd3,  1'b0, 1'b1, 1'b0, 2'd2, 4'd0, 2'd3, 4'd2, 2'd0, 4'd3, 16'hFFF9, 16'h0006, 1'b0},
    {2'd3, 4'd11, 1'b1, 1'b1, 1'b1, 2'd3, 4'd2, 2'd0, 4'd0, 2'd1, 4'd2, 16'hA9C3, 16'hF5E1, 1'b0},
    {2'd0, 4'd8,  1'b0, 1'b1, 1'b1, 2'd0, 4'd4, 2'd2, 4'd1, 2'd3, 4'd0, 16'h0D2B, 16'h7E96, 1'b1},
    {2'd1, 4'd4,  1'b1, 1'b0, 1'b0, 2'd1, 4'd3, 2'd0, 4'd1, 2'd0, 4'd0, 16'h0015, 16'hFF0A, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] p, input logic [3:0] s);
    int pv, sv;
    case (p) 2'd0: pv = 2; 2'd1: pv = 3; 2'd2: pv = 5; default: pv = 7; endcase
    if (s <= 4'd3) sv = 2 * (int'(s) + 1);
    else           sv = 1 << s;
    return pv * sv / 2;
  endfunction

  function automatic int gap_of(input logic [1:0] p, input logic [3:0] s);
    int pv;
    case (p) 2'd0: pv = 1; 2'd1: pv = 3; 2'd2: pv = 5; default: pv = 7; endcase
    return pv * (2 ** (int'(s) + 1));
  endfunction

  task automatic run_frame(input logic [59:0] v, input int stray_at);
    logic [1:0]  sel;
    logic [24:0] c;
    logic [15:0] tx, peer, mask, cap, rxv;
    logic        cn, cpol, cpha, lsb, ps, csv;
    int n, h, dl, dt, cyc, edges, first, last, prev_edge, hmin, hmax, bitk, tdone, limit;
    bit got_done, post_ok;
    sel = v[59:58]; c = v[57:33]; tx = v[32:17]; peer = v[16:1]; cn = v[0];
    n = int'(c[24:21]) + 1; cpol = c[20]; cpha = c[19]; lsb = c[18];
    h  = half_of(c[17:16], c[15:12]);
    dl = gap_of(c[11:10], c[9:6]);
    dt = gap_of(c[5:4], c[3:0]);
    mask = 16'((17'd1 << n) - 17'd1);
    @(negedge clk);
    cfg_bank[int'(sel)*25 +: 25] = c;
    cfg_sel = sel; tx_data = tx; cont = cn;
    miso = lsb ? peer[0] : peer[n-1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk(cs_n == 1'b0, "R2", "cs_n after start", longint'(cs_n), 0);
    chk(sclk == cpol, "R5", "rest level at start", longint'(sclk), longint'(cpol));
    edges = 0; first = -1; last = -1; prev_edge = -1; hmin = 1 << 30; hmax = 0;
    bitk = 0; cap = '0; got_done = 0; tdone = 0; rxv = '0; csv = 1'b0;
    ps = sclk;
    limit = dl + 2 * n * h + h + dt + 20;
    while (!got_done && cyc < limit) begin
      @(negedge clk);
      cyc++;
      start = (stray_at != 0 && cyc == stray_at);
      if (sclk != ps) begin
        edges++;
        if (first < 0) first = cyc;
        else begin
          if (cyc - prev_edge < hmin) hmin = cyc - prev_edge;
          if (cyc - prev_edge > hmax) hmax = cyc - prev_edge;
        end
        prev_edge = cyc;
        last = cyc;
        if (((edges % 2) == 1) == (cpha == 1'b0)) begin
          if (lsb) cap[bitk] = mosi;
          else     cap = {cap[14:0], mosi};
          bitk++;
          if (bitk < n) miso = lsb ? peer[bitk] : peer[n-1-bitk];
        end
      end
      ps = sclk;
      if (done) begin
        got_done = 1; tdone = cyc; rxv = rx_data; csv = cs_n;
      end
    end
    start = 1'b0;
    chk(got_done, "R7", "done seen", longint'(got_done), 1);
    chk(first == dl + (cpha ? 0 : h), "R2", "lead to first edge", first, dl + (cpha ? 0 : h));
    chk(hmin == h && hmax == h, "R3 R12", "half period", hmax, h);
    chk(edges == 2 * n, "R4", "edge count", edges, 2 * n);
    chk(cap == (tx & mask), "R6 R5", "bits seen on mosi", cap, tx & mask);
    chk(rxv == (peer & mask), "R8 R6", "received word", rxv, peer & mask);
    chk(tdone - last == dt + (cpha ? h : 0), "R7", "last edge to done", tdone - last, dt + (cpha ? h : 0));
    chk(csv == !cn, cn ? "R9" : "R7", "cs_n at done", longint'(csv), longint'(!cn));
    post_ok = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || cs_n != !cn || sclk != cpol) post_ok = 0;
    end
    chk(post_ok, cn ? "R9" : "R11", "quiet after done", longint'(post_ok), 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cont = 1'b0; miso = 1'b0;
    cfg_bank = '0; cfg_sel = '0; tx_data = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R1", "control outputs in reset",
        longint'({cs_n, sclk, done}), 3'b100);
    chk(mosi == 1'b0 && rx_data == 16'h0, "R1", "data outputs in reset",
        longint'({mosi, rx_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) run_frame(VEC[i], 0);

    // R10: sizes 2 and 0 are too short
    for (int bad = 0; bad < 3; bad += 2) begin
      bit quiet;
      @(negedge clk);
      cfg_bank[24:0] = {4'(bad), 1'b0, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0};
      cfg_sel = 2'd0; cont = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      quiet = 1;
      for (int k = 0; k < 30; k++) begin
        if (cs_n != 1'b1 || done) quiet = 0;
        @(negedge clk);
      end
      chk(quiet, "R10", "short size start ignored", longint'(quiet), 1);
    end

    // R11: stray start inside the bit phase
    run_frame(VEC[0], 5);
    // R11: stray start inside the lead delay
    run_frame(VEC[2], 3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule